// File: doc/BRIEF.md
# Stack-Top Register Index Remapper

This unit keeps the state needed to emulate an eight-deep floating-point register stack on top of a flat register file. It has two registers. One is a 3-bit pointer to the current top of the stack. The other is a single translation-mode bit. Commands from the execution pipeline can step the pointer up or down, write an immediate value into it, read it back, and turn translation mode on or off.

A purely combinational port translates architectural register numbers into physical ones. It takes a 5-bit index and a flag that marks a vector-class (SIMD) access. The index is rotated only when three things are true: translation mode is on, the access is scalar, and the index lies in the stack window 0 to 7. In that case the physical number is the sum of index and pointer, taken modulo 8. Every other access keeps its number.

The read path delivers the pointer as the upper 32-bit half of the shared 64-bit emulation state word. The pointer sits in the low bits of that half, and the flags occupy the other half outside this unit. The register file, the extended-precision format and tag handling are not part of this unit.

Top module: `fstack_remap`

## Requirements
- R1: After reset the pointer is 0 and translation mode is off.
- R2: An increment command sets the pointer to (pointer + 1) mod 8 and a decrement command sets it to (pointer − 1) mod 8, both visible from the next cycle.
- R3: A load command writes `load_val` into the pointer. When commands collide, load beats increment, increment beats decrement, and with no command the pointer holds.
- R4: While `rd_en` is 1, `rd_word` carries the pointer zero-extended into bits [2:0] of the 32-bit upper state half. While `rd_en` is 0, `rd_word` is 0.
- R5: `tm_on` sets translation mode to 1 and `tm_off` clears it to 0 from the next cycle. If both are asserted, clear wins. With neither, the mode holds.
- R6: With translation mode 1, `arch_vec` 0 and `arch_idx` below 8, `phys_idx` equals (`arch_idx` + pointer) mod 8.
- R7: With translation mode 0, or with `arch_idx` of 8 or more, `phys_idx` equals `arch_idx`.
- R8: With `arch_vec` 1, `phys_idx` equals `arch_idx` whatever the mode and pointer.
- R9: The remap port is combinational in the index and uses the registered pointer and mode. A command changes the mapping from the cycle after it is issued.
- R10: `tm_state` shows the current translation-mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_inc | input | 1 | Step the pointer up by one |
| top_dec | input | 1 | Step the pointer down by one |
| top_load | input | 1 | Write `load_val` into the pointer |
| load_val | input | 3 | Immediate value for load |
| rd_en | input | 1 | Read request for the pointer |
| rd_word | output | 32 | Upper state half holding the pointer |
| tm_on | input | 1 | Set translation mode |
| tm_off | input | 1 | Clear translation mode |
| tm_state | output | 1 | Current translation mode |
| arch_idx | input | 5 | Architectural register index |
| arch_vec | input | 1 | Access is vector-class |
| phys_idx | output | 5 | Physical register index |

## Verification
A corrupted pointer does not stay hidden. If translation mode is on, the next scalar access to indices 0 to 7 lands on the wrong physical register, and the next read shows a different value in the same cycle it is requested. A lost or wrong mode bit shows at once on `tm_state` and flips every stack-window access between rotated and pass-through. The bench therefore checks the read word and the remap output against its model on every cycle. It sweeps the index across every pointer value, so an off-by-one in the wrap or the window bound appears in the first cycle after the bad update.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    TOP_HOLD = 2'd0,
    TOP_LOAD = 2'd1,
    TOP_INC  = 2'd2,
    TOP_DEC  = 2'd3
  } top_op_e;

  // R3: load over increment over decrement
  function automatic top_op_e pick_op(input logic ld, input logic up, input logic dn);
    if (ld)      return TOP_LOAD;
    else if (up) return TOP_INC;
    else if (dn) return TOP_DEC;
    else         return TOP_HOLD;
  endfunction

endpackage

// File: rtl/fsr_top_ctr.sv
module fsr_top_ctr
  import fsr_pkg::*;
#(
  parameter int TOP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  top_op_e          op,
  input  logic [TOP_W-1:0] load_val,
  output logic [TOP_W-1:0] top_q
);

  localparam logic [TOP_W-1:0] ONE = TOP_W'(1);

  function automatic logic [TOP_W-1:0] step(input logic [TOP_W-1:0] cur, input top_op_e o,
                                            input logic [TOP_W-1:0] imm);
    case (o)
      TOP_LOAD: return imm;
      TOP_INC:  return cur + ONE;
      TOP_DEC:  return cur - ONE;
      default:  return cur;
    endcase
  endfunction

  // named events for the checks
  logic wrap_up, wrap_dn;
  assign wrap_up = (op == TOP_INC) && (top_q == {TOP_W{1'b1}});
  assign wrap_dn = (op == TOP_DEC) && (top_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) top_q <= '0;
    else        top_q <= step(top_q, op, load_val);
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> top_q == '0);
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_INC) |=> top_q == $past(top_q) + ONE);
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_DEC) |=> top_q == $past(top_q) - ONE);
  p_wrap_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> top_q == '0);
  p_wrap_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dn |=> top_q == {TOP_W{1'b1}});
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_LOAD) |=> top_q == $past(load_val));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_HOLD) |=> $stable(top_q));

endmodule

// File: rtl/fsr_mode_reg.sv
module fsr_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic tm_q
);

  logic collide;
  assign collide = set_req && clr_req;

  always_ff @(posedge clk) begin
    if (!rst_n)       tm_q <= 1'b0;
    else if (clr_req) tm_q <= 1'b0;
    else if (set_req) tm_q <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !tm_q);
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !clr_req) |=> tm_q);
  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !tm_q);
  p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> !tm_q);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !clr_req) |=> $stable(tm_q));

endmodule

// File: rtl/fsr_remap.sv
module fsr_remap #(
  parameter int TOP_W = 3,
  parameter int IDX_W = 5
) (
  input  logic [TOP_W-1:0] top,
  input  logic             tm,
  input  logic [IDX_W-1:0] arch,
  input  logic             vec,
  output logic [IDX_W-1:0] phys
);

  localparam int STACK_N = 1 << TOP_W;
  localparam logic [IDX_W-1:0] WIN_END = IDX_W'(STACK_N);

  function automatic logic [IDX_W-1:0] rotate(input logic [IDX_W-1:0] a, input logic [TOP_W-1:0] t);
    logic [TOP_W-1:0] s;
    s = a[TOP_W-1:0] + t;
    return IDX_W'(s);
  endfunction

  logic in_window, rotate_en;
  assign in_window = arch < WIN_END;
  assign rotate_en = tm && !vec && in_window;
  assign phys      = rotate_en ? rotate(arch, top) : arch;

  always_comb begin
    if (vec) p_vec_r8: assert (phys == arch);
    if (!tm || !in_window) p_pass_r7: assert (phys == arch);
    if (rotate_en) p_range_r6: assert (phys < WIN_END);
  end

endmodule

// File: rtl/fstack_remap.sv
module fstack_remap
  import fsr_pkg::*;
#(
  parameter int TOP_W  = 3,
  parameter int IDX_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              top_inc,
  input  logic              top_dec,
  input  logic              top_load,
  input  logic [TOP_W-1:0]  load_val,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  input  logic              tm_on,
  input  logic              tm_off,
  output logic              tm_state,
  input  logic [IDX_W-1:0]  arch_idx,
  input  logic              arch_vec,
  output logic [IDX_W-1:0]  phys_idx
);

  top_op_e          op;
  logic [TOP_W-1:0] top_q;
  logic             tm_q;

  assign op = pick_op(top_load, top_inc, top_dec);

  fsr_top_ctr #(.TOP_W(TOP_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .op(op), .load_val(load_val), .top_q(top_q)
  );

  fsr_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .set_req(tm_on), .clr_req(tm_off), .tm_q(tm_q)
  );

  fsr_remap #(.TOP_W(TOP_W), .IDX_W(IDX_W)) u_remap (
    .top(top_q), .tm(tm_q), .arch(arch_idx), .vec(arch_vec), .phys(phys_idx)
  );

  assign tm_state = tm_q;
  assign rd_word  = rd_en ? WORD_W'(top_q) : '0;

  always_comb begin
    if (!rd_en) p_rd_idle_r4: assert (rd_word == '0);
  end

  p_load_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (top_load && (top_inc || top_dec)) |=> top_q == $past(load_val));
  p_map_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (top_load && !tm_on && !tm_off) |=> tm_q == $past(tm_q));

endmodule

// File: tb/fstack_remap_test.sv
module fstack_remap_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        top_inc = 0, top_dec = 0, top_load = 0, rd_en = 0;
  logic [2:0]  load_val = 0;
  logic        tm_on = 0, tm_off = 0;
  logic [4:0]  arch_idx = 0;
  logic        arch_vec = 0;
  logic [31:0] rd_word;
  logic        tm_state;
  logic [4:0]  phys_idx;

  int n_run = 0, n_fail = 0;
  int m_top = 0;
  int m_tm = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fstack_remap uut (
    .clk(clk), .rst_n(rst_n), .top_inc(top_inc), .top_dec(top_dec), .top_load(top_load),
    .load_val(load_val), .rd_en(rd_en), .rd_word(rd_word), .tm_on(tm_on), .tm_off(tm_off),
    .tm_state(tm_state), .arch_idx(arch_idx), .arch_vec(arch_vec), .phys_idx(phys_idx)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model, then advance one clock
  task automatic tick(string tag);
    int exp_p;
    #1;
    chk({tag, "/R4 rd_word"}, int'(rd_word), rd_en ? m_top : 0);
    chk({tag, "/R10 tm_state"}, int'(tm_state), m_tm);
    if (arch_vec) begin
      exp_p = arch_idx;
      chk({tag, "/R8 vec pass"}, int'(phys_idx), exp_p);
    end else if (m_tm == 1 && arch_idx < 8) begin
      exp_p = (arch_idx + m_top) % 8;
      chk({tag, "/R6 rotate"}, int'(phys_idx), exp_p);
    end else begin
      exp_p = arch_idx;
      chk({tag, "/R7 pass"}, int'(phys_idx), exp_p);
    end
    @(posedge clk);
    if (!rst_n) begin m_top = 0; m_tm = 0; end
    else begin
      if (top_load)     m_top = load_val;
      else if (top_inc) m_top = (m_top + 1) % 8;
      else if (top_dec) m_top = (m_top + 7) % 8;
      if (tm_off)      m_tm = 0;
      else if (tm_on)  m_tm = 1;
    end
    @(negedge clk);
  endtask

  task automatic cmd(bit ld, bit up, bit dn, int v, bit s, bit c);
    top_load = ld; top_inc = up; top_dec = dn; load_val = 3'(v); tm_on = s; tm_off = c;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rd_en = 1; arch_idx = 5'd3;
    cmd(1, 1, 0, 5, 1, 0);
    tick("R1 in reset");
    tick("R1 in reset");
    rst_n = 1;
    cmd(0, 0, 0, 0, 0, 0);
    tick("R1 after reset");
    // R2: increment through the wrap
    for (int i = 0; i < 9; i++) begin cmd(0, 1, 0, 0, 0, 0); tick("R2 inc"); end
    // R2: decrement through the wrap
    for (int i = 0; i < 10; i++) begin cmd(0, 0, 1, 0, 0, 0); tick("R2 dec"); end
    // R3: loads and priority
    cmd(1, 0, 0, 6, 0, 0); tick("R3 load");
    cmd(1, 1, 1, 2, 0, 0); tick("R3 load prio");
    cmd(0, 1, 1, 0, 0, 0); tick("R3 inc prio");
    cmd(0, 0, 0, 0, 0, 0); tick("R3 hold");
    // R4: read disabled
    rd_en = 0; tick("R4 idle"); rd_en = 1;
    // R5: mode set, collide, hold
    cmd(0, 0, 0, 0, 1, 0); tick("R5 set");
    cmd(0, 0, 0, 0, 0, 0); tick("R5 hold");
    cmd(0, 0, 0, 0, 1, 1); tick("R5 collide");
    cmd(0, 0, 0, 0, 1, 0); tick("R5 set again");
    // R6/R7/R8/R9: sweep index for every pointer with mode on
    for (int t = 0; t < 8; t++) begin
      cmd(1, 0, 0, t, 0, 0); tick("R9 load then map");
      cmd(0, 0, 0, 0, 0, 0);
      for (int ix = 0; ix < 32; ix++) begin
        arch_idx = 5'(ix);
        arch_vec = 0; tick("R6 sweep");
        arch_vec = 1; tick("R8 sweep");
      end
      arch_vec = 0;
    end
    // R7: mode off passes through
    cmd(0, 0, 0, 0, 0, 1); tick("R5 clear");
    cmd(0, 0, 0, 0, 0, 0);
    for (int ix = 0; ix < 10; ix++) begin arch_idx = 5'(ix); tick("R7 mode off"); end
    // random mix
    for (int i = 0; i < 600; i++) begin
      cmd(bit'($urandom % 5 == 0), bit'($urandom % 2), bit'($urandom % 2),
          int'($urandom % 8), bit'($urandom % 4 == 0), bit'($urandom % 5 == 0));
      rd_en = bit'($urandom % 4 != 0);
      arch_idx = 5'($urandom % 32);
      arch_vec = bit'($urandom % 6 == 0);
      tick("R9 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule